// File: doc/BRIEF.md
# Stream Port Data Cache

This block sits between a coprocessor and a wide memory bus. The coprocessor reads and writes 32-bit words on numbered stream ports. The block turns that traffic into aligned 64-bit bus transfers. Every port owns a small read slot and a separate write slot. Each slot has two lines. A bus word goes into the line chosen by the lowest bit of its word address, so one slot can hold a pair of adjacent bus words.

The block does not snoop the bus. It keeps its contents correct only at the two stream synchronization points. A space-acquire on a port drops that port's read lines, so the next reads fetch fresh data. A space-commit on a port writes back every dirty byte that falls inside the committed byte range. It signals completion only after the bus has accepted each of those writes.

Two mechanisms keep the bus busy ahead of demand. A read into the upper word of a pair fetches the next word into the other line. A write line whose eight bytes are all dirty is written back at once.

Top module: `scache_port_cache`

## Requirements
- R1: A read that misses issues one bus read at word address `cp_addr>>1`. It returns bits [31:0] of the bus word when `cp_addr[0]` is 0 and bits [63:32] when it is 1. `cp_ready` rises three cycles after acceptance when the grant comes at once.
- R2: A read that hits makes no bus transfer and raises `cp_ready` in the cycle after acceptance.
- R3: A read of an odd bus word W is followed, unless line 0 already holds W+1, by one bus read of W+1 into line 0. A later read of W+1 then hits.
- R4: Changes in memory are not seen by a port's read lines. After a space-acquire (`sy_put`=0) on that port, the next read misses and returns the new memory contents.
- R5: Writes are acknowledged in the cycle after acceptance and cause no bus transfer by themselves. A read on the same port still returns memory contents, because read and write slots are separate.
- R6: A space-commit (`sy_put`=1) with base B and length L writes each dirty byte at byte address A, where B <= A < B+L. Strobe bit k of a bus write selects byte k of the word, which sits at byte address word*8+k. Dirty bytes outside the range stay buffered. When nothing dirty lies in the range, no bus write is made.
- R7: When a write makes all eight bytes of a line dirty, that line is written back with strobe 0xFF without any space-commit.
- R8: A write to a line that holds dirty bytes of another bus word first writes back those bytes, using their own strobe.
- R9: Ports are independent. Data held for one port never satisfies a read on another port.
- R10: `mem_req`, `mem_addr`, `mem_we` and `mem_strb` hold steady until `mem_gnt`. No result is delivered while the grant is withheld.
- R11: After reset, `cp_ready`, `sy_done` and `mem_req` are low and all lines are empty and clean.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cp_valid | input | 1 | Coprocessor access request, held until `cp_ready` |
| cp_write | input | 1 | 1 = write, 0 = read |
| cp_port | input | PW | Stream port number |
| cp_addr | input | AW-2 | 32-bit word address, produced by the synchronizer |
| cp_wdata | input | 32 | Write data |
| cp_be | input | 4 | Byte enables of the write |
| cp_ready | output | 1 | One-cycle completion pulse |
| cp_rdata | output | 32 | Read data, valid with `cp_ready` |
| sy_valid | input | 1 | Synchronization request, held until `sy_done` |
| sy_put | input | 1 | 1 = space-commit, 0 = space-acquire |
| sy_port | input | PW | Port being synchronized |
| sy_base | input | AW | First committed byte address |
| sy_len | input | AW+1 | Committed byte count |
| sy_done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Bus request |
| mem_we | output | 1 | Bus write |
| mem_addr | output | AW-3 | Bus word address |
| mem_wdata | output | 64 | Bus write data |
| mem_strb | output | 8 | Byte strobes of the write |
| mem_gnt | input | 1 | Bus accepts the request in this cycle |
| mem_rvalid | input | 1 | Read data returned, at least one cycle after the grant |
| mem_rdata | input | 64 | Read data |

## Verification
A read hit or a write is due one cycle after acceptance. A miss with an immediate grant is due three cycles after acceptance, and a withheld grant pushes it back by one cycle for each stalled cycle. A space-acquire finishes one cycle after acceptance. A space-commit finishes after both lines of the port have been scanned and their writes granted.

The bench drives each request at a falling edge and counts falling edges until the completion pulse. It compares that latency with these figures where a requirement names one. It lets trailing prefetches and write-backs settle before it reads its own bus-transfer counters and memory model.

// File: rtl/scache_pkg.sv
package scache_pkg;
    localparam int CP_BYTES  = 4;
    localparam int BUS_BYTES = 8;
    localparam int CP_W      = 8 * CP_BYTES;
    localparam int BUS_W     = 8 * BUS_BYTES;

    typedef enum logic [2:0] {
        SC_IDLE,
        SC_RD_REQ,
        SC_RD_WAIT,
        SC_PF_REQ,
        SC_PF_WAIT,
        SC_WB_REQ,
        SC_PUT
    } sc_fsm_e;
endpackage

// File: rtl/scache_lane_merge.sv
// Merges one 32-bit write into a 64-bit write line and extends its dirty mask.
module scache_lane_merge
    import scache_pkg::*;
(
    input  logic [BUS_W-1:0]     line_i,
    input  logic [BUS_BYTES-1:0] dirty_i,
    input  logic                 lane_i,
    input  logic [CP_W-1:0]      wdata_i,
    input  logic [CP_BYTES-1:0]  be_i,
    output logic [BUS_W-1:0]     line_o,
    output logic [BUS_BYTES-1:0] dirty_o
);
    for (genvar k = 0; k < BUS_BYTES; k++) begin : g_byte
        logic hit;
        assign hit = be_i[k % CP_BYTES] && (lane_i == 1'((k / CP_BYTES) % 2));
        assign line_o[8*k +: 8] = hit ? wdata_i[8*(k % CP_BYTES) +: 8] : line_i[8*k +: 8];
        assign dirty_o[k]       = dirty_i[k] | hit;
    end
endmodule

// File: rtl/scache_range_mask.sv
// Marks the bytes of one bus word that fall inside [base, base+len).
module scache_range_mask
    import scache_pkg::*;
#(
    parameter int AW = 12
)(
    input  logic [AW-4:0]        word_i,
    input  logic [AW-1:0]        base_i,
    input  logic [AW:0]          len_i,
    output logic [BUS_BYTES-1:0] mask_o
);
    logic [AW:0] lo_ext;
    logic [AW:0] hi_ext;
    assign lo_ext = {1'b0, base_i};
    assign hi_ext = lo_ext + len_i;

    for (genvar k = 0; k < BUS_BYTES; k++) begin : g_byte
        logic [AW:0] a;
        assign a         = {1'b0, word_i, 3'(k)};
        assign mask_o[k] = (a >= lo_ext) && (a < hi_ext);
    end
endmodule

// File: rtl/scache_port_cache.sv
module scache_port_cache
    import scache_pkg::*;
#(
    parameter int NPORTS = 2,
    parameter int AW     = 12,
    localparam int PW    = (NPORTS > 1) ? $clog2(NPORTS) : 1,
    localparam int WW    = AW - 3,
    localparam int TW    = AW - 4
)(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cp_valid,
    input  logic                 cp_write,
    input  logic [PW-1:0]        cp_port,
    input  logic [AW-3:0]        cp_addr,
    input  logic [CP_W-1:0]      cp_wdata,
    input  logic [CP_BYTES-1:0]  cp_be,
    output logic                 cp_ready,
    output logic [CP_W-1:0]      cp_rdata,
    input  logic                 sy_valid,
    input  logic                 sy_put,
    input  logic [PW-1:0]        sy_port,
    input  logic [AW-1:0]        sy_base,
    input  logic [AW:0]          sy_len,
    output logic                 sy_done,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [WW-1:0]        mem_addr,
    output logic [BUS_W-1:0]     mem_wdata,
    output logic [BUS_BYTES-1:0] mem_strb,
    input  logic                 mem_gnt,
    input  logic                 mem_rvalid,
    input  logic [BUS_W-1:0]     mem_rdata
);
    typedef struct packed {
        sc_fsm_e                                        fsm;
        logic [NPORTS-1:0][1:0]                         rv;
        logic [NPORTS-1:0][1:0][TW-1:0]                 rtag;
        logic [NPORTS-1:0][1:0][BUS_W-1:0]              rdat;
        logic [NPORTS-1:0][1:0][TW-1:0]                 wtag;
        logic [NPORTS-1:0][1:0][BUS_W-1:0]              wdat;
        logic [NPORTS-1:0][1:0][BUS_BYTES-1:0]          wdirty;
        logic [PW-1:0]                                  port;
        logic                                           line;
        logic [WW-1:0]                                  baddr;
        logic                                           get_op;
        logic                                           cp_ready;
        logic [CP_W-1:0]                                rdata;
        logic                                           sy_done;
    } sc_state_t;

    sc_state_t st_d, st_q;

    // current coprocessor access decoded
    logic [WW-1:0]        cw;
    logic                 cl;
    logic [TW-1:0]        ct;
    logic [TW-1:0]        ct_nx;
    logic [TW-1:0]        fill_nx;
    logic [BUS_W-1:0]     m_line;
    logic [BUS_BYTES-1:0] m_dirty;
    logic [BUS_BYTES-1:0] r_mask;
    logic [BUS_BYTES-1:0] put_mask;

    assign cw      = cp_addr[AW-3:1];
    assign cl      = cw[0];
    assign ct      = cw[WW-1:1];
    assign ct_nx   = ct + 1'b1;
    assign fill_nx = st_q.baddr[WW-1:1] + 1'b1;

    scache_lane_merge u_merge (
        .line_i  (st_q.wdat[cp_port][cl]),
        .dirty_i (st_q.wdirty[cp_port][cl]),
        .lane_i  (cp_addr[0]),
        .wdata_i (cp_wdata),
        .be_i    (cp_be),
        .line_o  (m_line),
        .dirty_o (m_dirty)
    );

    scache_range_mask #(.AW(AW)) u_range (
        .word_i (WW'({st_q.wtag[st_q.port][st_q.line], st_q.line})),
        .base_i (sy_base),
        .len_i  (sy_len),
        .mask_o (r_mask)
    );

    assign put_mask = st_q.wdirty[st_q.port][st_q.line] & r_mask;
    assign cp_ready = st_q.cp_ready;
    assign cp_rdata = st_q.rdata;
    assign sy_done  = st_q.sy_done;

    always_comb begin
        st_d          = st_q;
        st_d.cp_ready = 1'b0;
        st_d.sy_done  = 1'b0;
        mem_req       = 1'b0;
        mem_we        = 1'b0;
        mem_addr      = st_q.baddr;
        mem_wdata     = st_q.wdat[st_q.port][st_q.line];
        mem_strb      = '0;
        case (st_q.fsm)
            SC_IDLE: begin
                if (!st_q.cp_ready && !st_q.sy_done) begin
                    if (sy_valid) begin
                        st_d.port   = sy_port;
                        st_d.get_op = !sy_put;
                        st_d.line   = 1'b0;
                        if (!sy_put) begin
                            st_d.rv[sy_port] = '0;
                            st_d.sy_done     = 1'b1;
                        end else begin
                            st_d.fsm = SC_PUT;
                        end
                    end else if (cp_valid && !cp_write) begin
                        st_d.port  = cp_port;
                        st_d.line  = cl;
                        st_d.baddr = cw;
                        if (st_q.rv[cp_port][cl] && st_q.rtag[cp_port][cl] == ct) begin
                            st_d.cp_ready = 1'b1;
                            st_d.rdata    = cp_addr[0] ? st_q.rdat[cp_port][cl][BUS_W-1:CP_W]
                                                       : st_q.rdat[cp_port][cl][CP_W-1:0];
                            if (cl && !(st_q.rv[cp_port][0] && st_q.rtag[cp_port][0] == ct_nx)) begin
                                st_d.baddr = cw + 1'b1;
                                st_d.line  = 1'b0;
                                st_d.fsm   = SC_PF_REQ;
                            end
                        end else begin
                            st_d.fsm = SC_RD_REQ;
                        end
                    end else if (cp_valid) begin
                        st_d.port = cp_port;
                        st_d.line = cl;
                        if (st_q.wdirty[cp_port][cl] != '0 && st_q.wtag[cp_port][cl] != ct) begin
                            st_d.fsm = SC_WB_REQ;
                        end else begin
                            st_d.wtag[cp_port][cl]   = ct;
                            st_d.wdat[cp_port][cl]   = m_line;
                            st_d.wdirty[cp_port][cl] = m_dirty;
                            st_d.cp_ready            = 1'b1;
                            if (&m_dirty) st_d.fsm = SC_WB_REQ;
                        end
                    end
                end
            end
            SC_RD_REQ, SC_PF_REQ: begin
                mem_req = 1'b1;
                if (mem_gnt) st_d.fsm = (st_q.fsm == SC_RD_REQ) ? SC_RD_WAIT : SC_PF_WAIT;
            end
            SC_RD_WAIT, SC_PF_WAIT: begin
                if (mem_rvalid) begin
                    st_d.rdat[st_q.port][st_q.line] = mem_rdata;
                    st_d.rv[st_q.port][st_q.line]   = 1'b1;
                    st_d.rtag[st_q.port][st_q.line] = st_q.baddr[WW-1:1];
                    st_d.fsm                        = SC_IDLE;
                    if (st_q.fsm == SC_RD_WAIT) begin
                        st_d.cp_ready = 1'b1;
                        st_d.rdata    = cp_addr[0] ? mem_rdata[BUS_W-1:CP_W] : mem_rdata[CP_W-1:0];
                        if (st_q.line && !(st_q.rv[st_q.port][0] && st_q.rtag[st_q.port][0] == fill_nx)) begin
                            st_d.baddr = st_q.baddr + 1'b1;
                            st_d.line  = 1'b0;
                            st_d.fsm   = SC_PF_REQ;
                        end
                    end
                end
            end
            SC_WB_REQ: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = WW'({st_q.wtag[st_q.port][st_q.line], st_q.line});
                mem_strb = st_q.wdirty[st_q.port][st_q.line];
                if (mem_gnt) begin
                    st_d.wdirty[st_q.port][st_q.line] = '0;
                    st_d.fsm                          = SC_IDLE;
                end
            end
            SC_PUT: begin
                mem_addr = WW'({st_q.wtag[st_q.port][st_q.line], st_q.line});
                mem_strb = put_mask;
                if (put_mask != '0) begin
                    mem_req = 1'b1;
                    mem_we  = 1'b1;
                end
                if (put_mask == '0 || mem_gnt) begin
                    st_d.wdirty[st_q.port][st_q.line] = st_q.wdirty[st_q.port][st_q.line] & ~put_mask;
                    if (st_q.line) begin
                        st_d.sy_done = 1'b1;
                        st_d.fsm     = SC_IDLE;
                    end else begin
                        st_d.line = 1'b1;
                    end
                end
            end
            default: st_d.fsm = SC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // bus request must not change or drop before it is granted
    assert_bus_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_strb));

    // prefetch always targets the even word that follows an odd one
    assert_pf_even_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.fsm == SC_PF_REQ) |-> mem_req && !mem_we && !mem_addr[0]);

    // no bus write ever carries an empty strobe
    assert_wr_strb_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> mem_strb != '0);

    // an acquire leaves the port without valid read lines
    assert_get_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.sy_done && st_q.get_op |-> st_q.rv[st_q.port] == '0);

    // completion is a single-cycle pulse
    assert_ready_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cp_ready |=> !cp_ready);

    for (genvar p = 0; p < NPORTS; p++) begin : g_chk_port
        for (genvar l = 0; l < 2; l++) begin : g_chk_line
            // a fully dirty line is never left waiting in idle
            assert_no_full_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
                st_q.fsm == SC_IDLE |-> st_q.wdirty[p][l] != '1);
        end
    end
endmodule

// File: tb/scache_port_cache_tb.sv
module scache_port_cache_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NPORTS     = 2;
    localparam int AW         = 12;
    localparam int PW         = 1;
    localparam int WW         = AW - 3;
    localparam int WDOG       = 20000;

    logic clk = 0;
    logic rst_n = 0;
    logic cp_valid = 0, cp_write = 0;
    logic [PW-1:0] cp_port = '0;
    logic [AW-3:0] cp_addr = '0;
    logic [31:0] cp_wdata = '0;
    logic [3:0] cp_be = '0;
    logic cp_ready;
    logic [31:0] cp_rdata;
    logic sy_valid = 0, sy_put = 0;
    logic [PW-1:0] sy_port = '0;
    logic [AW-1:0] sy_base = '0;
    logic [AW:0] sy_len = '0;
    logic sy_done;
    logic mem_req, mem_we;
    logic [WW-1:0] mem_addr;
    logic [63:0] mem_wdata;
    logic [7:0] mem_strb;
    logic mem_gnt = 1;
    logic mem_rvalid = 0;
    logic [63:0] mem_rdata = '0;

    logic [63:0] mem [0:(1<<WW)-1];
    int nrd = 0, nwr = 0;
    logic [WW-1:0] last_waddr = '0;
    logic [7:0] last_strb = '0;
    logic poke_en = 0;
    logic [WW-1:0] poke_a = '0;
    logic [63:0] poke_d = '0;
    int checks = 0, errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    scache_port_cache #(.NPORTS(NPORTS), .AW(AW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cp_valid(cp_valid), .cp_write(cp_write), .cp_port(cp_port), .cp_addr(cp_addr),
        .cp_wdata(cp_wdata), .cp_be(cp_be), .cp_ready(cp_ready), .cp_rdata(cp_rdata),
        .sy_valid(sy_valid), .sy_put(sy_put), .sy_port(sy_port), .sy_base(sy_base),
        .sy_len(sy_len), .sy_done(sy_done),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_strb(mem_strb), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    function automatic logic [63:0] pat(int i);
        return {16'hD00D ^ 16'(i), 16'(i * 7), 16'h5A00 + 16'(i), 16'(i) ^ 16'h0F0F};
    endfunction

    initial begin
        for (int i = 0; i < (1 << WW); i++) mem[i] = pat(i);
    end

    // memory model: read data one cycle after grant
    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (poke_en) mem[poke_a] <= poke_d;
        if (rst_n && mem_req && mem_gnt) begin
            if (mem_we) begin
                for (int k = 0; k < 8; k++)
                    if (mem_strb[k]) mem[mem_addr][8*k +: 8] <= mem_wdata[8*k +: 8];
                nwr        <= nwr + 1;
                last_waddr <= mem_addr;
                last_strb  <= mem_strb;
            end else begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= mem[mem_addr];
                nrd        <= nrd + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (8) @(negedge clk);
    endtask

    task automatic cp_read(input int port, input logic [AW-1:0] ba, output logic [31:0] data, output int lat);
        cp_port = PW'(port); cp_addr = ba[AW-1:2]; cp_write = 0; cp_valid = 1; lat = 0;
        do begin @(negedge clk); lat++; end while (!cp_ready);
        data = cp_rdata; cp_valid = 0;
    endtask

    task automatic cp_wr(input int port, input logic [AW-1:0] ba, input logic [31:0] d, input logic [3:0] be, output int lat);
        cp_port = PW'(port); cp_addr = ba[AW-1:2]; cp_write = 1; cp_wdata = d; cp_be = be; cp_valid = 1; lat = 0;
        do begin @(negedge clk); lat++; end while (!cp_ready);
        cp_valid = 0; cp_write = 0;
    endtask

    task automatic sync(input bit put, input int port, input logic [AW-1:0] base, input int len);
        sy_put = put; sy_port = PW'(port); sy_base = base; sy_len = (AW+1)'(len); sy_valid = 1;
        do @(negedge clk); while (!sy_done);
        sy_valid = 0;
    endtask

    task automatic poke(input int w, input logic [63:0] d);
        poke_a = WW'(w); poke_d = d; poke_en = 1;
        @(negedge clk);
        poke_en = 0;
    endtask

    task automatic t_reset();
        chk(cp_ready == 0, "R11 cp_ready", 64'(cp_ready), 0);
        chk(sy_done == 0, "R11 sy_done", 64'(sy_done), 0);
        chk(mem_req == 0, "R11 mem_req", 64'(mem_req), 0);
    endtask

    task automatic t_read_miss_hit();
        logic [31:0] d; int lat; int r0;
        r0 = nrd;
        cp_read(0, 12'h024, d, lat);
        chk(d == pat(4)[63:32], "R1 miss data", 64'(d), 64'(pat(4)[63:32]));
        chk(lat == 3, "R1 miss latency", 64'(lat), 3);
        settle();
        chk(nrd - r0 == 1, "R1 one bus read", 64'(nrd - r0), 1);
        cp_read(0, 12'h020, d, lat);
        chk(d == pat(4)[31:0], "R2 hit data", 64'(d), 64'(pat(4)[31:0]));
        chk(lat == 1, "R2 hit latency", 64'(lat), 1);
        settle();
        chk(nrd - r0 == 1, "R2 no bus read", 64'(nrd - r0), 1);
    endtask

    task automatic t_prefetch();
        logic [31:0] d; int lat; int r0;
        r0 = nrd;
        cp_read(0, 12'h028, d, lat);
        chk(d == pat(5)[31:0], "R3 odd word data", 64'(d), 64'(pat(5)[31:0]));
        settle();
        chk(nrd - r0 == 2, "R3 miss plus prefetch", 64'(nrd - r0), 2);
        cp_read(0, 12'h034, d, lat);
        chk(d == pat(6)[63:32], "R3 prefetched data", 64'(d), 64'(pat(6)[63:32]));
        chk(lat == 1, "R3 prefetched hit", 64'(lat), 1);
    endtask

    task automatic t_coherency();
        logic [31:0] d; int lat; int r0;
        poke(6, 64'h1111_2222_3333_4444);
        cp_read(0, 12'h030, d, lat);
        chk(d == pat(6)[31:0], "R4 stale before acquire", 64'(d), 64'(pat(6)[31:0]));
        sync(0, 0, '0, 0);
        r0 = nrd;
        cp_read(0, 12'h030, d, lat);
        chk(d == 32'h3333_4444, "R4 fresh after acquire", 64'(d), 64'h3333_4444);
        settle();
        chk(nrd - r0 == 1, "R4 refetch", 64'(nrd - r0), 1);
    endtask

    task automatic t_ports();
        logic [31:0] d; int lat; int r0;
        r0 = nrd;
        cp_read(1, 12'h020, d, lat);
        chk(d == pat(4)[31:0], "R9 other port data", 64'(d), 64'(pat(4)[31:0]));
        settle();
        chk(nrd - r0 == 1, "R9 other port misses", 64'(nrd - r0), 1);
    endtask

    task automatic t_write_put();
        logic [31:0] d; int lat; int w0;
        w0 = nwr;
        cp_wr(0, 12'h040, 32'h1122_3344, 4'hF, lat);
        chk(lat == 1, "R5 write ack", 64'(lat), 1);
        settle();
        chk(nwr == w0, "R5 no bus write", 64'(nwr - w0), 0);
        cp_read(0, 12'h040, d, lat);
        chk(d == pat(8)[31:0], "R5 read slot separate", 64'(d), 64'(pat(8)[31:0]));
        sync(1, 0, 12'h040, 2);
        settle();
        chk(nwr - w0 == 1 && last_strb == 8'h03, "R6 partial range strobe", 64'(last_strb), 64'h03);
        chk(mem[8][31:0] == {pat(8)[31:16], 16'h3344}, "R6 partial range data",
            64'(mem[8][31:0]), 64'({pat(8)[31:16], 16'h3344}));
        sync(1, 0, 12'h040, 8);
        settle();
        chk(nwr - w0 == 2 && last_strb == 8'h0C, "R6 remaining strobe", 64'(last_strb), 64'h0C);
        chk(mem[8][31:0] == 32'h1122_3344, "R6 committed data", 64'(mem[8][31:0]), 64'h1122_3344);
        sync(1, 0, 12'h040, 8);
        settle();
        chk(nwr - w0 == 2, "R6 nothing dirty", 64'(nwr - w0), 2);
    endtask

    task automatic t_full();
        int lat; int w0;
        w0 = nwr;
        cp_wr(0, 12'h048, 32'hAAAA_5555, 4'hF, lat);
        settle();
        chk(nwr == w0, "R7 half line kept", 64'(nwr - w0), 0);
        cp_wr(0, 12'h04C, 32'h1234_5678, 4'hF, lat);
        settle();
        chk(nwr - w0 == 1 && last_strb == 8'hFF, "R7 full line flushed", 64'(last_strb), 64'hFF);
        chk(last_waddr == 9, "R7 flush address", 64'(last_waddr), 9);
        chk(mem[9] == 64'h1234_5678_AAAA_5555, "R7 flush data", mem[9], 64'h1234_5678_AAAA_5555);
    endtask

    task automatic t_evict();
        int lat; int w0;
        w0 = nwr;
        cp_wr(1, 12'h050, 32'hCAFE_F00D, 4'h3, lat);
        cp_wr(1, 12'h060, 32'h0BAD_BEEF, 4'hF, lat);
        settle();
        chk(nwr - w0 == 1 && last_waddr == 10, "R8 evict address", 64'(last_waddr), 10);
        chk(last_strb == 8'h03, "R8 evict strobe", 64'(last_strb), 64'h03);
        chk(mem[10][15:0] == 16'hF00D && mem[10][31:16] == pat(10)[31:16], "R8 evict data",
            64'(mem[10][31:0]), 64'({pat(10)[31:16], 16'hF00D}));
        sync(1, 1, 12'h060, 8);
        settle();
        chk(mem[12][31:0] == 32'h0BAD_BEEF && last_strb == 8'h0F, "R6 commit after evict",
            64'(mem[12][31:0]), 64'h0BAD_BEEF);
    endtask

    task automatic t_stall();
        logic [31:0] d; int lat;
        mem_gnt = 0;
        fork
            cp_read(1, 12'h080, d, lat);
            begin repeat (5) @(negedge clk); mem_gnt = 1; end
        join
        chk(d == pat(16)[31:0], "R10 stalled data", 64'(d), 64'(pat(16)[31:0]));
        chk(lat == 7, "R10 stalled latency", 64'(lat), 7);
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_read_miss_hit();
        t_prefetch();
        t_coherency();
        t_ports();
        t_write_put();
        t_full();
        t_evict();
        t_stall();
        settle();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule